// File: doc/BRIEF.md
# Split-Read Free-Running Cycle Counter

A wide free-running cycle counter that software reads through a 32-bit register port, one half at a time. Because the two halves come from separate accesses, the pair can be torn: the counter may carry into its upper half between the two reads, or the reading program may be interrupted between them. The block does not freeze a copy of the upper half. Instead, a small tracker watches the read order and publishes a validity flag in the top bit of the control register.

Software reads the lower half, then the upper half, then the control register. It repeats that loop until the flag is set, and then combines the two halves it read. The tracker treats an interrupt or exception taken during the window, a change of the upper half inside the window, or an upper-half read with no window open as a torn read. One bit of the control register starts and stops counting.

The counter width is a parameter (default 64). Each half is zero-extended onto the 32-bit read bus.

Top module: `tick64_split_read`

## Requirements
- R1: The register map is decoded from `reg_addr`. Control is at 0x103, the lower half at 0x104 and the upper half at 0x105. `reg_rdata` shows the addressed register in the same cycle. Any other address reads 0.
- R2: After reset the counter is 0, counting is disabled, and the control register reads 0. Its bit 31 (validity) and bit 0 (enable) are both 0.
- R3: A write to the control address loads bit 0 of `reg_wdata` into the enable, and control bit 0 reads that enable back from the next cycle. Writes to the lower or upper address leave the count unchanged.
- R4: While enabled, the counter grows by exactly 1 per clock and wraps to 0 after its all-ones value. While disabled it holds its value.
- R5: A read (`reg_rd` high) of the lower half opens a new window and sets control bit 31 to 1 from the next cycle, clearing any earlier torn indication.
- R6: If `trap_taken` is high in any cycle after the lower-half read, up to and including the cycle of the upper-half read, control bit 31 becomes 0. When no window is open, `trap_taken` leaves bit 31 unchanged.
- R7: If the upper half differs between the lower-half read cycle and the upper-half read cycle, control bit 31 becomes 0 after the upper-half read.
- R8: An upper-half read with no open window makes control bit 31 read 0. Every upper-half read closes the window.
- R9: Reading the control register changes no tracking state. Bit 31 keeps its value across repeated control reads until the next lower-half read or torn event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe; marks a read access in this cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| trap_taken | input | 1 | High in a cycle where an interrupt or exception is taken |

## Verification
The bench runs a 16-bit counter so that carries into the upper half, and a full wrap, happen within a short run. The read loop is tried in five forms:
- A clean lower/upper/control sequence away from any carry, which must report valid.
- The same sequence with an interrupt inside the window, which isolates the trap path.
- A sequence placed so that the carry falls between the two reads, which isolates the upper-half comparison.
- An upper-half read with no prior lower read, which isolates the sequencing rule.
- An interrupt with no window open, which must not disturb a valid flag.

Writes to the count halves, disable and re-enable, and the wrap are all compared cycle by cycle against a behavioural model.

// File: rtl/tick64_pkg.sv
package tick64_pkg;

    localparam int REG_W      = 32;
    localparam int STATUS_BIT = 31;
    localparam int ENABLE_BIT = 0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_HIGH = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tick64_decode.sv
module tick64_decode
    import tick64_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == CTRL_ADDR) begin
            sel = SEL_CTRL;
        end else if (addr == LOW_ADDR) begin
            sel = SEL_LOW;
        end else if (addr == HIGH_ADDR) begin
            sel = SEL_HIGH;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/tick64_counter.sv
module tick64_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_wval,
    output logic [CNT_W-1:0] count,
    output logic             enabled
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (en_wr) begin
            st_d.en = en_wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign enabled = st_q.en;

endmodule

// File: rtl/tick64_read_tracker.sv
module tick64_read_tracker #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_rd,
    input  logic              high_rd,
    input  logic              trap,
    input  logic [HALF_W-1:0] hi_now,
    output logic              valid,
    output logic              window_open
);

    typedef struct packed {
        logic              open;
        logic              ok;
        logic [HALF_W-1:0] snap;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (low_rd) begin
            // a fresh window forgets any earlier tear
            st_d.open = 1'b1;
            st_d.ok   = 1'b1;
            st_d.snap = hi_now;
        end else begin
            if (trap && st_q.open) begin
                st_d.ok = 1'b0;
            end
            if (high_rd) begin
                if (!st_q.open || (hi_now != st_q.snap)) begin
                    st_d.ok = 1'b0;
                end
                st_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid       = st_q.ok;
    assign window_open = st_q.open;

endmodule

// File: rtl/tick64_split_read.sv
module tick64_split_read
    import tick64_pkg::*;
#(
    parameter int                CNT_W     = 64,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              trap_taken
);

    localparam int HALF_W = CNT_W / 2;

    reg_sel_e         sel;
    logic [CNT_W-1:0] cnt_val;
    logic             en_val;
    logic             ok_val;
    logic             open_val;
    logic             low_rd;
    logic             high_rd;
    logic             ctrl_wr;

    tick64_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .LOW_ADDR (LOW_ADDR),
        .HIGH_ADDR(HIGH_ADDR)
    ) u_decode (
        .addr(reg_addr),
        .sel (sel)
    );

    assign low_rd  = reg_rd && (sel == SEL_LOW);
    assign high_rd = reg_rd && (sel == SEL_HIGH);
    assign ctrl_wr = reg_wr && (sel == SEL_CTRL);

    tick64_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (ctrl_wr),
        .en_wval(reg_wdata[ENABLE_BIT]),
        .count  (cnt_val),
        .enabled(en_val)
    );

    tick64_read_tracker #(
        .HALF_W(HALF_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .low_rd     (low_rd),
        .high_rd    (high_rd),
        .trap       (trap_taken),
        .hi_now     (cnt_val[CNT_W-1:HALF_W]),
        .valid      (ok_val),
        .window_open(open_val)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                reg_rdata[STATUS_BIT] = ok_val;
                reg_rdata[ENABLE_BIT] = en_val;
            end
            SEL_LOW:  reg_rdata = REG_W'(cnt_val[HALF_W-1:0]);
            SEL_HIGH: reg_rdata = REG_W'(cnt_val[CNT_W-1:HALF_W]);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick64_split_read_chk.sv
module tick64_split_read_chk #(
    parameter int                CNT_W     = 64,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              trap_taken,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              en_val,
    input logic              ok_val,
    input logic              open_val
);

    logic lo_access;
    logic hi_access;
    logic ctl_access;

    assign lo_access  = reg_rd && (reg_addr == LOW_ADDR);
    assign hi_access  = reg_rd && (reg_addr == HIGH_ADDR);
    assign ctl_access = reg_rd && (reg_addr == CTRL_ADDR);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_val |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_val |=> $stable(cnt_val));

    p_low_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_access |=> (ok_val && open_val));

    p_trap_tears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && open_val && !lo_access) |=> !ok_val);

    p_orphan_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_access && !open_val) |=> (!ok_val && !open_val));

    p_status_read_benign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_access && !(trap_taken && open_val)) |=> $stable(ok_val));

endmodule

bind tick64_split_read tick64_split_read_chk #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .LOW_ADDR (LOW_ADDR),
    .HIGH_ADDR(HIGH_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .trap_taken(trap_taken),
    .cnt_val   (cnt_val),
    .en_val    (en_val),
    .ok_val    (ok_val),
    .open_val  (open_val)
);

// File: tb/tick64_split_read_tb.sv
module tick64_split_read_tb;

    localparam int CNT_W = 16;
    localparam int H     = CNT_W / 2;
    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LOW  = 12'h104;
    localparam logic [11:0] A_HIGH = 12'h105;
    localparam logic [11:0] A_NONE = 12'h0A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = A_NONE;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_taken = 1'b0;

    always #4 clk = ~clk;

    tick64_split_read #(.CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trap_taken(trap_taken)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [CNT_W-1:0] m_cnt = '0;
    bit               m_en = 0, m_ok = 0, m_open = 0;
    logic [H-1:0]     m_snap = '0;
    logic [31:0]      last_rd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rdata(input logic [11:0] a);
        logic [31:0] v = '0;
        if (a == A_CTRL) begin
            v[31] = m_ok;
            v[0]  = m_en;
        end else if (a == A_LOW) begin
            v = 32'(m_cnt[H-1:0]);
        end else if (a == A_HIGH) begin
            v = 32'(m_cnt[CNT_W-1:H]);
        end
        return v;
    endfunction

    task automatic step(input logic [11:0] a, input bit rd, input bit wr,
                        input logic [31:0] wd, input bit tr);
        logic [H-1:0] hi;
        @(negedge clk);
        reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd; trap_taken = tr;
        #1;
        last_rd = reg_rdata;
        chk("model R1 R4", reg_rdata, model_rdata(a));
        @(posedge clk);
        hi = m_cnt[CNT_W-1:H];
        if (rd && a == A_LOW) begin
            m_open = 1; m_ok = 1; m_snap = hi;
        end else begin
            if (tr && m_open) m_ok = 0;
            if (rd && a == A_HIGH) begin
                if (!m_open || hi != m_snap) m_ok = 0;
                m_open = 0;
            end
        end
        if (m_en) m_cnt = m_cnt + 1'b1;
        if (wr && a == A_CTRL) m_en = wd[0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(A_NONE, 0, 0, '0, 0);
    endtask

    task automatic wait_low(input int v);
        while (m_cnt[H-1:0] != H'(v)) step(A_NONE, 0, 0, '0, 0);
    endtask

    task automatic clean_seq();
        wait_low(10);
        step(A_LOW, 1, 0, '0, 0);
        step(A_HIGH, 1, 0, '0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 decode
        step(A_CTRL, 1, 0, '0, 0); chk("R2 ctrl", last_rd, 32'h0);
        step(A_LOW, 0, 0, '0, 0);  chk("R2 low", last_rd, 32'h0);
        step(A_HIGH, 0, 0, '0, 0); chk("R2 high", last_rd, 32'h0);
        step(A_NONE, 1, 0, '0, 0); chk("R1 unmapped", last_rd, 32'h0);
        idle(4);
        step(A_LOW, 0, 0, '0, 0);  chk("R4 disabled hold", last_rd, 32'h0);

        // R3 enable
        step(A_CTRL, 0, 1, 32'h1, 0);
        step(A_CTRL, 0, 0, '0, 0); chk("R3 enable readback", last_rd & 32'h1, 32'h1);
        idle(5);

        // R3 write to low ignored
        step(A_LOW, 0, 1, 32'hAA, 0); v0 = last_rd;
        step(A_LOW, 0, 0, '0, 0);     chk("R3 low write ignored", last_rd, v0 + 1);
        step(A_HIGH, 0, 1, 32'h55, 0); v0 = last_rd;
        step(A_HIGH, 0, 0, '0, 0);     chk("R3 high write ignored", last_rd, v0);

        // R5 clean sequence, R9 repeated status reads
        clean_seq();
        step(A_CTRL, 1, 0, '0, 0); chk("R5 clean valid", last_rd[31], 1'b1);
        step(A_CTRL, 1, 0, '0, 0); chk("R9 repeat read", last_rd[31], 1'b1);

        // R6 trap inside window
        wait_low(40);
        step(A_LOW, 1, 0, '0, 0);
        step(A_NONE, 0, 0, '0, 1);
        step(A_HIGH, 1, 0, '0, 0);
        step(A_CTRL, 1, 0, '0, 0); chk("R6 trap tears", last_rd[31], 1'b0);
        step(A_CTRL, 1, 0, '0, 0); chk("R9 torn persists", last_rd[31], 1'b0);

        // R5 low read clears torn flag
        step(A_LOW, 1, 0, '0, 0);
        step(A_CTRL, 1, 0, '0, 0); chk("R5 rearm", last_rd[31], 1'b1);

        // R6 trap on high-read cycle
        step(A_HIGH, 1, 0, '0, 1);
        step(A_CTRL, 1, 0, '0, 0); chk("R6 trap at high read", last_rd[31], 1'b0);

        // R7 carry between halves
        wait_low(254);
        step(A_LOW, 1, 0, '0, 0);  chk("R7 low before carry", last_rd, 32'd254);
        step(A_NONE, 0, 0, '0, 0);
        step(A_HIGH, 1, 0, '0, 0);
        step(A_CTRL, 1, 0, '0, 0); chk("R7 carry tears", last_rd[31], 1'b0);

        // R8 orphan high read
        clean_seq();
        step(A_CTRL, 1, 0, '0, 0); chk("R8 pre valid", last_rd[31], 1'b1);
        step(A_HIGH, 1, 0, '0, 0);
        step(A_CTRL, 1, 0, '0, 0); chk("R8 orphan high", last_rd[31], 1'b0);

        // R6 trap outside window has no effect
        clean_seq();
        step(A_NONE, 0, 0, '0, 1);
        step(A_NONE, 0, 0, '0, 1);
        step(A_CTRL, 1, 0, '0, 0); chk("R6 trap no window", last_rd[31], 1'b1);

        // R3 disable, R4 hold
        step(A_CTRL, 0, 1, 32'h0, 0);
        step(A_CTRL, 1, 0, '0, 0); chk("R3 disable readback", last_rd & 32'h1, 32'h0);
        step(A_LOW, 0, 0, '0, 0);  v0 = last_rd;
        idle(6);
        step(A_LOW, 0, 0, '0, 0);  chk("R4 hold while disabled", last_rd, v0);

        // R4 wrap over full range
        step(A_CTRL, 0, 1, 32'h1, 0);
        step(A_LOW, 0, 0, '0, 0);  v0 = last_rd;
        idle((1 << CNT_W) - 1);
        step(A_LOW, 0, 0, '0, 0);  chk("R4 wrap period", last_rd, v0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule